// File: doc/BRIEF.md
# Operating-System Match Timer with Watchdog Reset

This block is a free-running system timer that software controls through a small word-addressed register port. A 32-bit up-counter advances once on every clock cycle in which the tick strobe is high. Four match channels compare the counter against their own 32-bit compare values. When the counter comes to equal a channel's compare value and that channel's interrupt is enabled, the channel latches a status flag and drives its interrupt line. The flag stays set until software writes a one to it.

The last match channel also serves as a watchdog. If bit 0 of the watchdog-arm register is set when that channel matches, the block emits a one-cycle system reset request and clears the arm register. The reset request does not depend on the channel's interrupt enable. Software loads the counter directly and reprograms compare values at any time. A match is taken only on the cycle in which equality begins, so a counter that is held still does not fire again and again.

Top module: `os_match_timer`

## Requirements
- R1: After reset the counter, all four compare registers, the interrupt-enable register, the watchdog-arm register and the status register read as zero, and every interrupt line and the reset request are low.
- R2: The counter increases by one on each clock with `tick_en` high and holds otherwise. It wraps from 0xFFFFFFFF to 0.
- R3: A write to the counter (byte offset 0x10) loads the written value and takes priority over a tick in the same cycle. Counting then continues from the loaded value.
- R4: When the counter becomes equal to compare register i (offset 4*i) and enable bit i of the interrupt-enable register (offset 0x1C) is set, status bit i (offset 0x14, bit i) and `irq_o[i]` are high from the clock edge after the one that produced equality.
- R5: A match on a channel whose enable bit is clear sets no status bit and raises no interrupt.
- R6: A match fires only on the cycle in which equality begins. Clearing the status while the counter still equals the compare value does not set it again.
- R7: Writing the status register clears every bit that is written as one, leaves the others, and drops the matching interrupt lines on the next edge.
- R8: The interrupt-enable register keeps bits 11:0 of a write, and bits 31:12 read as zero.
- R9: When channel 3 matches while bit 0 of the watchdog-arm register (offset 0x18) is set, `wdog_rst_o` is high for exactly one cycle, starting at the edge after equality. The whole arm register becomes zero, and this happens whatever the state of interrupt enable bit 3.
- R10: A channel 3 match with arm bit 0 clear produces no reset request and leaves the arm register unchanged.
- R11: Every register reads back through `bus_rdata` one cycle after `bus_rd`. Unmapped offsets read as zero, and `bus_rdata` holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| tick_en | input | 1 | Counter advance strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| irq_o | output | 4 | Per-channel interrupt lines, one per status bit |
| wdog_rst_o | output | 1 | One-cycle system reset request from the watchdog channel |

## Verification
Register writes take effect at the edge that samples them, and read data appears at the edge after `bus_rd`. The bench therefore drives on the falling edge and samples on the next falling edge. The counter reaches a compare value on one edge, and the status bit, interrupt line and reset pulse follow on the next edge. For this reason the bench checks that the outputs are still low at the falling edge right after the last tick. It then checks them high one falling edge later, and for the reset pulse it checks that the output is low again one falling edge after that. Checks that something did not happen wait several cycles beyond the point where the effect would be due and then read the register state back through the port.

// File: rtl/os_tmr_pkg.sv
package os_tmr_pkg;
  // Word indices of the fixed registers; compare registers occupy words 0..NUM_CH-1
  localparam int unsigned CNT_WORD  = 4;
  localparam int unsigned STAT_WORD = 5;
  localparam int unsigned WDOG_WORD = 6;
  localparam int unsigned IEN_WORD  = 7;

  typedef enum logic [2:0] {
    SEL_MATCH,
    SEL_CNT,
    SEL_STAT,
    SEL_WDOG,
    SEL_IEN,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/os_tmr_counter.sv
module os_tmr_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] cnt_o
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = load_i | tick_i;
    cnt_d  = load_i ? load_val_i : cnt_q + DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/os_tmr_match.sv
module os_tmr_match #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0] match_o,
  output logic              hit_o
);
  logic [DATA_W-1:0] match_q;
  logic              eq, eq_q;

  always_comb begin
    eq    = (cnt_i == match_q);
    hit_o = eq & ~eq_q;         // equality just began
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    match_q <= '0;
    else if (wr_i) match_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq;
  end

  assign match_o = match_q;
endmodule

// File: rtl/os_tmr_ctrl.sv
module os_tmr_ctrl #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned IEN_W   = 12,
  parameter int unsigned WDOG_CH = NUM_CH - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic              stat_wr_i,
  input  logic              ien_wr_i,
  input  logic              wdog_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NUM_CH-1:0] status_o,
  output logic [IEN_W-1:0]  ien_o,
  output logic [DATA_W-1:0] wdog_o,
  output logic              wdog_rst_o
);
  logic [NUM_CH-1:0] status_q, status_d, set_v, clr_v;
  logic [IEN_W-1:0]  ien_q;
  logic [DATA_W-1:0] wdog_q, wdog_d;
  logic              wdog_en, fire, pulse_q;

  always_comb begin
    set_v    = hit_i & ien_q[NUM_CH-1:0];
    clr_v    = stat_wr_i ? (wdata_i[NUM_CH-1:0] & status_q) : '0;
    status_d = (status_q & ~clr_v) | set_v;   // a new event wins over a clear
    fire     = hit_i[WDOG_CH] & wdog_q[0];
    wdog_en  = fire | wdog_wr_i;
    wdog_d   = fire ? '0 : wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ien_q <= '0;
    else if (ien_wr_i) ien_q <= wdata_i[IEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wdog_q <= '0;
    else if (wdog_en) wdog_q <= wdog_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= fire;
  end

  assign status_o   = status_q;
  assign ien_o      = ien_q;
  assign wdog_o     = wdog_q;
  assign wdog_rst_o = pulse_q;
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
  import os_tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned IEN_W  = 12,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq_o,
  output logic              wdog_rst_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]             word;
  logic [1:0]                    unused_byte_sel;
  reg_sel_e                      sel;
  logic [NUM_CH-1:0][DATA_W-1:0] match_arr;
  logic [NUM_CH-1:0]             hit_v, status_v;
  logic [DATA_W-1:0]             cnt_q, wdog_q, rd_mux, rdata_q;
  logic [IEN_W-1:0]              ien_q;

  assign word            = bus_addr[ADDR_W-1:2];
  assign unused_byte_sel = bus_addr[1:0];

  always_comb begin
    sel = SEL_NONE;
    if (word < WORD_W'(NUM_CH))         sel = SEL_MATCH;
    else if (word == WORD_W'(CNT_WORD))  sel = SEL_CNT;
    else if (word == WORD_W'(STAT_WORD)) sel = SEL_STAT;
    else if (word == WORD_W'(WDOG_WORD)) sel = SEL_WDOG;
    else if (word == WORD_W'(IEN_WORD))  sel = SEL_IEN;
  end

  os_tmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_en),
    .load_i     (bus_wr && sel == SEL_CNT),
    .load_val_i (bus_wdata),
    .cnt_o      (cnt_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    os_tmr_match #(.DATA_W(DATA_W)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (bus_wr && sel == SEL_MATCH && word == WORD_W'(g)),
      .wdata_i (bus_wdata),
      .cnt_i   (cnt_q),
      .match_o (match_arr[g]),
      .hit_o   (hit_v[g])
    );
  end

  os_tmr_ctrl #(
    .DATA_W (DATA_W),
    .NUM_CH (NUM_CH),
    .IEN_W  (IEN_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit_v),
    .stat_wr_i  (bus_wr && sel == SEL_STAT),
    .ien_wr_i   (bus_wr && sel == SEL_IEN),
    .wdog_wr_i  (bus_wr && sel == SEL_WDOG),
    .wdata_i    (bus_wdata),
    .status_o   (status_v),
    .ien_o      (ien_q),
    .wdog_o     (wdog_q),
    .wdog_rst_o (wdog_rst_o)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_MATCH: begin
        for (int k = 0; k < NUM_CH; k++)
          if (word == WORD_W'(k)) rd_mux = match_arr[k];
      end
      SEL_CNT:  rd_mux = cnt_q;
      SEL_STAT: rd_mux = {{(DATA_W-NUM_CH){1'b0}}, status_v};
      SEL_WDOG: rd_mux = wdog_q;
      SEL_IEN:  rd_mux = {{(DATA_W-IEN_W){1'b0}}, ien_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = status_v;
endmodule

// File: rtl/os_match_timer_chk.sv
module os_match_timer_chk
  import os_tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned IEN_W  = 12,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] irq_o,
  input logic              wdog_rst_o,
  input logic [DATA_W-1:0] cnt,
  input logic [NUM_CH-1:0] ien,
  input logic [DATA_W-1:0] wdog
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [1:0] unused_lsb;
  logic       cnt_wr, ien_rd;

  assign unused_lsb = bus_addr[1:0];
  assign cnt_wr     = bus_wr && bus_addr[ADDR_W-1:2] == WORD_W'(CNT_WORD);
  assign ien_rd     = bus_rd && bus_addr[ADDR_W-1:2] == WORD_W'(IEN_WORD);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !cnt_wr |=> cnt == $past(cnt) + DATA_W'(1));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !cnt_wr |=> $stable(cnt));

  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(bus_wdata));

  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~$past(irq_o) & ~$past(ien)) == '0);

  a_r8_ien_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ien_rd |=> bus_rdata[DATA_W-1:IEN_W] == '0);

  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |=> !wdog_rst_o);

  a_r9_arm_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |-> wdog == '0);

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind os_match_timer os_match_timer_chk #(
  .DATA_W (DATA_W),
  .NUM_CH (NUM_CH),
  .IEN_W  (IEN_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_o      (irq_o),
  .wdog_rst_o (wdog_rst_o),
  .cnt        (cnt_q),
  .ien        (ien_q[NUM_CH-1:0]),
  .wdog       (wdog_q)
);

// File: tb/os_match_timer_tb_top.sv
module os_match_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o;
  logic        wdog_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;

  always #10 clk = ~clk;   // 50 MHz

  os_match_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wdog_rst_o(wdog_rst_o)
  );

  always @(posedge clk) if (rst_n && wdog_rst_o) pulses <= pulses + 1;

  // {is_read, byte offset, data: write value or expected read value}
  localparam int NVEC = 16;
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 32'h1111_1111}, {1'b0, 8'h04, 32'h2222_2222},
    {1'b0, 8'h08, 32'h3333_3333}, {1'b0, 8'h0C, 32'h4444_4444},
    {1'b0, 8'h1C, 32'hFFFF_FFFF}, {1'b0, 8'h18, 32'h0000_0006},
    {1'b0, 8'h10, 32'h1234_5678},
    {1'b1, 8'h00, 32'h1111_1111}, {1'b1, 8'h04, 32'h2222_2222},
    {1'b1, 8'h08, 32'h3333_3333}, {1'b1, 8'h0C, 32'h4444_4444},
    {1'b1, 8'h1C, 32'h0000_0FFF}, {1'b1, 8'h18, 32'h0000_0006},
    {1'b1, 8'h10, 32'h1234_5678}, {1'b1, 8'h14, 32'h0000_0000},
    {1'b1, 8'h20, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 irq", {28'b0, irq_o}, 32'h0);
    chk("R1 wdog_rst", {31'b0, wdog_rst_o}, 32'h0);
    rd_chk("R1 cnt", 8'h10, 32'h0);
    rd_chk("R1 match0", 8'h00, 32'h0);
    rd_chk("R1 match3", 8'h0C, 32'h0);
    rd_chk("R1 ien", 8'h1C, 32'h0);
    rd_chk("R1 wdog", 8'h18, 32'h0);
    rd_chk("R1 status", 8'h14, 32'h0);

    // R11 / R8: register map walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][40]) rd_chk("R11 R8 table", VEC[i][39:32], VEC[i][31:0]);
      else            wr(VEC[i][39:32], VEC[i][31:0]);
    end
    wr(8'h1C, 32'h0);

    // R4: enabled match, timing
    wr(8'h1C, 32'h1); wr(8'h00, 32'h100); wr(8'h10, 32'hFE);
    run_ticks(2);
    chk("R4 not yet", {28'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R4 irq", {28'b0, irq_o}, 32'h1);
    rd_chk("R4 status", 8'h14, 32'h1);

    // R6: clear while still equal, no re-trigger
    wr(8'h14, 32'h1);
    repeat (3) @(negedge clk);
    chk("R6 irq", {28'b0, irq_o}, 32'h0);
    rd_chk("R6 status", 8'h14, 32'h0);

    // R5: match with enable clear
    wr(8'h1C, 32'h0); wr(8'h10, 32'hFE);
    run_ticks(2);
    repeat (2) @(negedge clk);
    chk("R5 irq", {28'b0, irq_o}, 32'h0);
    rd_chk("R5 status", 8'h14, 32'h0);

    // R7: two channels, partial write-one-to-clear
    wr(8'h1C, 32'h6); wr(8'h04, 32'h200); wr(8'h08, 32'h200); wr(8'h10, 32'h1FF);
    run_ticks(1);
    @(negedge clk);
    chk("R7 both set", {28'b0, irq_o}, 32'h6);
    wr(8'h14, 32'hA);
    chk("R7 irq after clear", {28'b0, irq_o}, 32'h4);
    rd_chk("R7 status", 8'h14, 32'h4);
    wr(8'h14, 32'hF); wr(8'h1C, 32'h0);

    // R9: watchdog fires, interrupt 3 disabled
    wr(8'h0C, 32'h300); wr(8'h18, 32'hFFFF_0001); wr(8'h10, 32'h2FD);
    run_ticks(3);
    chk("R9 pulse not yet", {31'b0, wdog_rst_o}, 32'h0);
    @(negedge clk);
    chk("R9 pulse high", {31'b0, wdog_rst_o}, 32'h1);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'b0, wdog_rst_o}, 32'h0);
    rd_chk("R9 arm cleared", 8'h18, 32'h0);
    rd_chk("R9 no status", 8'h14, 32'h0);
    chk("R9 pulse count", pulses, 32'd1);

    // R10: arm bit 0 clear, no reset
    wr(8'h18, 32'h2); wr(8'h10, 32'h2FD);
    run_ticks(3);
    repeat (3) @(negedge clk);
    chk("R10 no pulse", pulses, 32'd1);
    rd_chk("R10 arm kept", 8'h18, 32'h2);

    // R2: wrap and hold
    wr(8'h10, 32'hFFFF_FFFF);
    run_ticks(1);
    rd_chk("R2 wrap", 8'h10, 32'h0);
    repeat (5) @(negedge clk);
    rd_chk("R2 hold", 8'h10, 32'h0);

    // R3: load with tick in the same cycle, then continue
    @(negedge clk); tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h1F4;
    @(negedge clk); bus_wr = 1'b0;
    repeat (2) @(negedge clk);
    tick_en = 1'b0;
    rd_chk("R3 load then count", 8'h10, 32'h1F6);

    // R1: reset applied mid-run
    wr(8'h1C, 32'hF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 irq after reset", {28'b0, irq_o}, 32'h0);
    rd_chk("R1 cnt after reset", 8'h10, 32'h0);
    rd_chk("R1 ien after reset", 8'h1C, 32'h0);
    rd_chk("R1 wdog after reset", 8'h18, 32'h0);
    rd_chk("R1 match1 after reset", 8'h04, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule